// File: doc/BRIEF.md
# Subtractive GCD Engine

This block computes the greatest common divisor of two unsigned operands (8 bits by default) without any divider. A one-cycle start pulse captures both operands into working registers. A small controller then steers a single shared subtractor. On every clock it takes the smaller working value away from the larger one, until the two values match. The matching value is copied into a result register and a ready flag is raised. Ready and the result stay put until the next accepted start.

The controller and the datapath talk only through control strobes (load, subtract-into-first, subtract-into-second, capture, clear) and comparator status (equal, greater). If either operand is zero, the subtraction loop could never end. In that case the block skips the loop, finishes at once with a zero result and raises an error flag. A start pulse that arrives while a computation is running is ignored. Reset is synchronous and active high.

Top module: `gcd_engine`

## Requirements
- R1: After a clock edge with `rst` high, `ready`, `zero_err` and `result` are all 0 and the block is idle, waiting for a start.
- R2: When the block is idle or finished, a high `start` at a clock edge captures `opa` and `opb`. After that edge `ready` and `zero_err` are 0.
- R3: While the working values differ, each clock performs exactly one subtraction. If the first value is greater, it becomes first minus second; otherwise the second becomes second minus first.
- R4: At the clock edge where the working values are equal, `result` takes that value and `ready` goes to 1. With k subtractions, `ready` is first seen high on the (k+2)-th falling edge after the falling edge that raised `start`; for operands 48 and 18 that is the 6th.
- R5: While `ready` is 1 and no start is accepted, `ready`, `zero_err` and `result` hold their values, whatever `opa` and `opb` do.
- R6: A `start` pulse during a running computation has no effect: the result is that of the operands captured first.
- R7: If either captured operand is 0, then after the capturing edge `ready` is 1, `zero_err` is 1 and `result` is 0.
- R8: A later accepted start with both operands non-zero clears `zero_err`.
- R9: Equal operands finish with no subtraction: `ready` is first seen high on the 2nd falling edge after `start` was raised.
- R10: Extreme operands give the correct result: 255 with 1 gives 1, and 255 with 255 gives 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (accepted when not busy) |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| result | output | W | Greatest common divisor, valid while ready is 1 |
| ready | output | 1 | Computation finished |
| zero_err | output | 1 | A zero operand was supplied |

## Verification
On every cycle the assertions check several things. The two subtract strobes never fire together, and a strobe fires only when the comparator favours that side. The working registers never grow except on a load. While ready is high with no error, the result equals both working values. An error always comes with ready high and a zero result. Ready and the result stay frozen until a start arrives. Only the bench scenarios can show that the final value is truly the greatest common divisor, and they also cover the exact finishing latency, the ignored mid-run start and the clearing of the error flag.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } gcd_state_e;

    typedef struct packed {
        gcd_state_e state;
        logic       ready;
        logic       err;
    } gcd_ctrl_t;

endpackage

// File: rtl/gcd_cmp.sv
module gcd_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         eq,
    output logic         gt
);
    always_comb begin
        eq = (lhs == rhs);
        gt = (lhs > rhs);
    end
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic op_zero,
    input  logic eq,
    input  logic gt,
    output logic ld,
    output logic sub_x,
    output logic sub_y,
    output logic save_z,
    output logic clr_z,
    output logic ready,
    output logic err
);
    gcd_ctrl_t c_d, c_q;
    logic      accept;

    always_comb begin
        c_d    = c_q;
        ld     = 1'b0;
        sub_x  = 1'b0;
        sub_y  = 1'b0;
        save_z = 1'b0;
        clr_z  = 1'b0;
        accept = 1'b0;
        case (c_q.state)
            ST_RUN: begin
                if (eq) begin
                    save_z    = 1'b1;
                    c_d.ready = 1'b1;
                    c_d.state = ST_DONE;
                end else if (gt) begin
                    sub_x = 1'b1;
                end else begin
                    sub_y = 1'b1;
                end
            end
            default: begin
                if (start) begin
                    accept    = 1'b1;
                    ld        = 1'b1;
                    c_d.ready = 1'b0;
                    c_d.err   = 1'b0;
                    if (op_zero) begin
                        clr_z     = 1'b1;
                        c_d.ready = 1'b1;
                        c_d.err   = 1'b1;
                        c_d.state = ST_DONE;
                    end else begin
                        c_d.state = ST_RUN;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.state <= ST_IDLE;
            c_q.ready <= 1'b0;
            c_q.err   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign ready = c_q.ready;
    assign err   = c_q.err;

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && !op_zero) |=> (!ready && !err && c_q.state == ST_RUN));

    assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (c_q.state == ST_RUN) |-> (!ready && !ld));

    assert_equal_finishes_R4: assert property (@(posedge clk) disable iff (rst)
        (c_q.state == ST_RUN && eq) |=> (ready && c_q.state == ST_DONE));

    assert_zero_op_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && op_zero) |=> (ready && err));
endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         ld,
    input  logic         sub_x,
    input  logic         sub_y,
    input  logic         save_z,
    input  logic         clr_z,
    output logic [W-1:0] x_val,
    output logic [W-1:0] y_val,
    output logic [W-1:0] z_val,
    output logic         op_zero
);
    typedef struct packed {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] z;
    } dp_regs_t;

    dp_regs_t     r_d, r_q;
    logic [W-1:0] minuend, subtrahend, diff;

    always_comb begin
        minuend    = sub_x ? r_q.x : r_q.y;
        subtrahend = sub_x ? r_q.y : r_q.x;
        diff       = minuend - subtrahend;
        op_zero    = (opa == '0) || (opb == '0);

        r_d = r_q;
        if (ld) begin
            r_d.x = opa;
            r_d.y = opb;
        end else if (sub_x) begin
            r_d.x = diff;
        end else if (sub_y) begin
            r_d.y = diff;
        end
        if (clr_z)
            r_d.z = '0;
        else if (save_z)
            r_d.z = r_q.x;
    end

    always_ff @(posedge clk) begin
        if (rst)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign x_val = r_q.x;
    assign y_val = r_q.y;
    assign z_val = r_q.z;

    assert_single_sub_R3: assert property (@(posedge clk) disable iff (rst)
        !(sub_x && sub_y));

    assert_sub_side_R3: assert property (@(posedge clk) disable iff (rst)
        sub_x |-> (r_q.x > r_q.y));

    assert_no_growth_R3: assert property (@(posedge clk) disable iff (rst)
        !ld |=> (r_q.x <= $past(r_q.x) && r_q.y <= $past(r_q.y)));
endmodule

// File: rtl/gcd_engine.sv
module gcd_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result,
    output logic         ready,
    output logic         zero_err
);
    logic         ld, sub_x, sub_y, save_z, clr_z;
    logic         eq, gt, op_zero;
    logic [W-1:0] x_val, y_val;

    gcd_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_zero (op_zero),
        .eq      (eq),
        .gt      (gt),
        .ld      (ld),
        .sub_x   (sub_x),
        .sub_y   (sub_y),
        .save_z  (save_z),
        .clr_z   (clr_z),
        .ready   (ready),
        .err     (zero_err)
    );

    gcd_cmp #(.W(W)) u_cmp (
        .lhs (x_val),
        .rhs (y_val),
        .eq  (eq),
        .gt  (gt)
    );

    gcd_datapath #(.W(W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .opa     (opa),
        .opb     (opb),
        .ld      (ld),
        .sub_x   (sub_x),
        .sub_y   (sub_y),
        .save_z  (save_z),
        .clr_z   (clr_z),
        .x_val   (x_val),
        .y_val   (y_val),
        .z_val   (result),
        .op_zero (op_zero)
    );

    assert_result_matches_R4: assert property (@(posedge clk) disable iff (rst)
        (ready && !zero_err) |-> (result == x_val && x_val == y_val));

    assert_err_zero_result_R7: assert property (@(posedge clk) disable iff (rst)
        zero_err |-> (ready && result == '0));

    assert_done_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> (ready && $stable(result) && $stable(zero_err)));
endmodule

// File: tb/gcd_engine_tb_top.sv
module gcd_engine_tb_top;
    localparam int W         = 8;
    localparam int CLK_HALF  = 5;
    localparam int WATCHDOG  = 100000;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] opa, opb;
    logic [W-1:0] result;
    logic         ready, zero_err;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string cur_tag  = "R1";

    // behavioural reference state
    int m_state = 0;  // 0 idle, 1 running, 2 finished
    int mx = 0, my = 0, mz = 0, mready = 0, merr = 0;

    gcd_engine #(.W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .opa      (opa),
        .opb      (opb),
        .result   (result),
        .ready    (ready),
        .zero_err (zero_err)
    );

    always #CLK_HALF clk = ~clk;

    function automatic int euclid(input int a, input int b);
        int p = a, q = b, t;
        while (q != 0) begin
            t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_state = 0; mx = 0; my = 0; mz = 0; mready = 0; merr = 0;
        end else if (m_state == 1) begin
            if (mx == my) begin
                mz = mx; mready = 1; m_state = 2;
            end else if (mx > my) begin
                mx = mx - my;
            end else begin
                my = my - mx;
            end
        end else if (start) begin
            mx = int'(opa); my = int'(opb);
            mready = 0; merr = 0;
            if (opa == 0 || opb == 0) begin
                mz = 0; mready = 1; merr = 1; m_state = 2;
            end else begin
                m_state = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(cur_tag, int'(ready), mready, "ready vs model");
            check(cur_tag, int'(zero_err), merr, "zero_err vs model");
            check(cur_tag, int'(result), mz, "result vs model");
        end
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // raise start for one cycle and return the falling edge count until ready
    task automatic launch(input int a, input int b, output int lat);
        opa   = W'(a);
        opb   = W'(b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!ready && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_case(input string tag, input int a, input int b);
        int lat;
        cur_tag = tag;
        launch(a, b, lat);
        check(tag, int'(result), euclid(a, b), "gcd result");
        check(tag, int'(zero_err), 0, "no error flag");
    endtask

    initial begin
        int lat;
        rst = 1'b1; start = 1'b0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(ready), 0, "ready after reset");
        check("R1", int'(zero_err), 0, "zero_err after reset");
        check("R1", int'(result), 0, "result after reset");
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(ready), 0, "idle without start");

        // R2 / R4: capture and latency
        cur_tag = "R4";
        opa = 8'd48; opb = 8'd18; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2", int'(ready), 0, "ready low after capture");
        lat = 1;
        while (!ready && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        check("R4", lat, 6, "finish latency for 48,18");
        check("R4", int'(result), 6, "gcd of 48,18");

        // R3: both subtraction directions
        run_case("R3", 18, 48);
        run_case("R3", 91, 35);
        run_case("R3", 13, 7);

        // R9: equal operands
        cur_tag = "R9";
        launch(17, 17, lat);
        check("R9", lat, 2, "equal operands latency");
        check("R9", int'(result), 17, "equal operands result");

        // R10: extreme operands
        run_case("R10", 255, 1);
        run_case("R10", 1, 255);
        run_case("R10", 255, 255);

        // R5: hold while finished, inputs wiggling
        cur_tag = "R5";
        for (int i = 0; i < 8; i++) begin
            opa = W'(i * 37 + 3);
            opb = W'(i * 11);
            @(negedge clk);
        end
        check("R5", int'(ready), 1, "ready held");
        check("R5", int'(result), 255, "result held");

        // R7: zero operands
        cur_tag = "R7";
        launch(0, 5, lat);
        check("R7", lat, 1, "zero operand latency");
        check("R7", int'(zero_err), 1, "zero_err raised");
        check("R7", int'(result), 0, "zero result");
        launch(7, 0, lat);
        check("R7", int'(zero_err), 1, "zero_err for second operand");

        // R8: error cleared by a good start
        run_case("R8", 12, 8);

        // R6: start while running is ignored
        cur_tag = "R6";
        opa = 8'd200; opb = 8'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        opa = 8'd10; opb = 8'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!ready && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        check("R6", int'(result), euclid(200, 3), "mid-run start ignored");

        // reset mid-run returns to idle (R1)
        cur_tag = "R1";
        opa = 8'd250; opb = 8'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1", int'(ready), 0, "ready after mid-run reset");
        check("R1", int'(result), 0, "result after mid-run reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule